// File: doc/BRIEF.md
# Segment Register Loader with Descriptor Cache

This block fills the hidden descriptor part of a set of segment registers. A load names a target register and gives a 16-bit selector. The selector picks an entry in either the global or the local descriptor table. The block checks the load, then fetches the 8-byte descriptor as two 32-bit reads through a request/response memory port. It unpacks the little-endian record and writes the decoded base, limit, granularity, privilege level and access byte into that register's cache entry, along with the selector itself.

Address translation logic reads a cache entry through a combinational read port. It never touches the table again. A load that would move into the code segment register, that names a register that does not exist, or that reaches past the end of the selected table is refused. A refused load raises a fault and does not read memory.

The load port is a valid/ready interface. A load is accepted on a cycle where both `ld_valid` and `ld_ready` are high, and `ld_ready` is high only while no load is in progress. The memory request port is also valid/ready. The block holds `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen. Responses have no back-pressure: exactly one `mem_rsp_valid` pulse is expected for each accepted request, after any delay.

Top module: `seg_load_unit`

## Requirements
- R1: The selector is decoded as follows. Bits 1:0 are the requested privilege and take no part in the fetch. Bit 2 picks the table (0 = global, 1 = local). Bits 15:3 are the index. The first read goes to the chosen table base plus index times 8.
- R2: An accepted load issues exactly two reads: the low dword at the descriptor address, then the high dword at that address plus 4. Each request stays valid with a stable address until it is accepted.
- R3: With d = {high dword, low dword}, the fields are decoded as: base = {d[63:56], d[39:16]}, limit = {d[51:48], d[15:0]}, granularity = d[55], access byte = d[47:40], privilege = d[46:45]. For example, low 0x0000FFFF with high 0x00CFFA00 gives base 0, limit 0xFFFFF, granularity 1, access 0xFA and privilege 3.
- R4: A successful load pulses `ld_done` for one cycle with `ld_fault` low. In that cycle the target entry is already valid and holds the new fields and selector. Every other entry is unchanged.
- R5: A load into register id `CODE_ID` (default 1) with `ld_xfer` = 0 (move source) is refused. The block pulses `ld_done` and `ld_fault` one cycle after acceptance, issues no read, and leaves the cache unchanged.
- R6: A load is refused in the same way (R5) when index*8+7 exceeds the 16-bit byte limit of the selected table. A descriptor whose end equals the limit is allowed.
- R7: `ld_ready` is high only while idle. `busy` rises the cycle after a load is accepted that will be fetched. It falls in the cycle where `ld_done` pulses, and it stays low for a refused load.
- R8: After reset, `busy` is 0, `ld_ready` is 1, and every cache entry reads invalid with all fields zero.
- R9: A load into the code segment register with `ld_xfer` = 1 (control-transfer source) is fetched and committed normally.
- R10: A load naming a register id of `NUM_SEGS` or above is refused in the same way (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load request accepted this cycle when valid |
| ld_selector | input | 16 | Selector to load |
| ld_seg_id | input | ID_W | Target segment register id |
| ld_xfer | input | 1 | Source tag: 1 = control transfer, 0 = move |
| gtab_base | input | 32 | Global table base address |
| gtab_limit | input | 16 | Global table byte limit |
| ltab_base | input | 32 | Local table base address |
| ltab_limit | input | 16 | Local table byte limit |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Load in progress |
| ld_done | output | 1 | One-cycle pulse: load finished |
| ld_fault | output | 1 | One-cycle pulse with ld_done: load refused |
| rd_seg_id | input | ID_W | Cache read port register id |
| rd_valid | output | 1 | Entry holds a loaded descriptor |
| rd_selector | output | 16 | Cached selector |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 20 | Cached limit |
| rd_gran | output | 1 | Cached granularity |
| rd_dpl | output | 2 | Cached privilege level |
| rd_access | output | 8 | Cached access byte |

## Verification
The bench uses the default parameters: six registers, so the 3-bit id has two unused codes, with register 1 as the code segment. The small table limits it drives reach both the exact-end boundary and refusals by overrun in each table. The unused id codes 6 and 7 reach the out-of-range refusal. Random ready and response delays on the memory port exercise the hold rule and the two-read order.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

  typedef struct packed {
    logic [15:0] selector;
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic [1:0]  dpl;
    logic [7:0]  access;
  } seg_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LO,
    ST_RSP_LO,
    ST_REQ_HI,
    ST_RSP_HI,
    ST_COMMIT
  } fetch_st_e;

  // Unpack a little-endian 8-byte descriptor held as two dwords.
  function automatic seg_entry_t unpack_desc(input logic [15:0] sel,
                                             input logic [31:0] lo,
                                             input logic [31:0] hi);
    seg_entry_t e;
    logic [63:0] d;
    d          = {hi, lo};
    e.selector = sel;
    e.base     = {d[63:56], d[39:16]};
    e.limit    = {d[51:48], d[15:0]};
    e.gran     = d[55];
    e.dpl      = d[46:45];
    e.access   = d[47:40];
    return e;
  endfunction

endpackage

// File: rtl/seg_sel_check.sv
module seg_sel_check #(
  parameter int NUM_SEGS = 6,
  parameter int CODE_ID  = 1,
  localparam int ID_W    = $clog2(NUM_SEGS)
) (
  input  logic [15:2]     sel_hi,
  input  logic [ID_W-1:0] seg_id,
  input  logic            xfer,
  input  logic [31:0]     gbase,
  input  logic [15:0]     glimit,
  input  logic [31:0]     lbase,
  input  logic [15:0]     llimit,
  output logic [31:0]     desc_addr,
  output logic            refuse
);
  logic [12:0] idx;
  logic        use_local;
  logic [15:0] end_off;
  logic [15:0] lim;
  logic        cs_move;
  logic        bad_id;
  logic        overrun;

  always_comb begin
    idx       = sel_hi[15:3];
    use_local = sel_hi[2];
    end_off   = {idx, 3'b111};
    lim       = use_local ? llimit : glimit;
    desc_addr = (use_local ? lbase : gbase) + {16'd0, idx, 3'b000};
    cs_move   = (seg_id == ID_W'(CODE_ID)) && !xfer;
    bad_id    = (32'(seg_id) >= NUM_SEGS);
    overrun   = end_off > lim;
    refuse    = cs_move || bad_id || overrun;
  end
endmodule

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
  import seg_load_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_addr,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        busy,
  output logic        commit,
  output logic [31:0] lo_dw,
  output logic [31:0] hi_dw
);
  fetch_st_e   st_q;
  logic [31:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      lo_dw  <= '0;
      hi_dw  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_REQ_LO;
          addr_q <= start_addr;
        end
        ST_REQ_LO: if (mem_req_ready) st_q <= ST_RSP_LO;
        ST_RSP_LO: if (mem_rsp_valid) begin
          lo_dw <= mem_rsp_data;
          st_q  <= ST_REQ_HI;
        end
        ST_REQ_HI: if (mem_req_ready) st_q <= ST_RSP_HI;
        ST_RSP_HI: if (mem_rsp_valid) begin
          hi_dw <= mem_rsp_data;
          st_q  <= ST_COMMIT;
        end
        ST_COMMIT: st_q <= ST_IDLE;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_valid = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
    mem_req_addr  = addr_q + ((st_q == ST_REQ_HI) ? 32'd4 : 32'd0);
    busy          = (st_q != ST_IDLE);
    commit        = (st_q == ST_COMMIT);
  end
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_load_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  localparam int ID_W    = $clog2(NUM_SEGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [ID_W-1:0] wid,
  input  seg_entry_t      wdata,
  input  logic [ID_W-1:0] rid,
  output seg_entry_t      rdata,
  output logic            rvalid
);
  seg_entry_t          ent_q [NUM_SEGS];
  logic [NUM_SEGS-1:0] vld_q;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (we && (wid == ID_W'(g))) begin
        ent_q[g] <= wdata;
        vld_q[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    rdata  = '0;
    rvalid = 1'b0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rid == ID_W'(i)) begin
        rdata  = ent_q[i];
        rvalid = vld_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_load_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int CODE_ID  = 1,
  localparam int ID_W    = $clog2(NUM_SEGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [15:0]     ld_selector,
  input  logic [ID_W-1:0] ld_seg_id,
  input  logic            ld_xfer,
  input  logic [31:0]     gtab_base,
  input  logic [15:0]     gtab_limit,
  input  logic [31:0]     ltab_base,
  input  logic [15:0]     ltab_limit,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [31:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            busy,
  output logic            ld_done,
  output logic            ld_fault,
  input  logic [ID_W-1:0] rd_seg_id,
  output logic            rd_valid,
  output logic [15:0]     rd_selector,
  output logic [31:0]     rd_base,
  output logic [19:0]     rd_limit,
  output logic            rd_gran,
  output logic [1:0]      rd_dpl,
  output logic [7:0]      rd_access
);
  logic            accept;
  logic            refuse;
  logic [31:0]     desc_addr;
  logic            fetch_busy;
  logic            commit;
  logic [31:0]     lo_dw;
  logic [31:0]     hi_dw;
  logic [ID_W-1:0] id_q;
  logic [15:0]     sel_q;
  logic            done_q;
  logic            fault_q;
  seg_entry_t      wentry;
  seg_entry_t      rentry;

  assign ld_ready = !fetch_busy;
  assign accept   = ld_valid && ld_ready;
  assign busy     = fetch_busy;
  assign ld_done  = done_q;
  assign ld_fault = fault_q;

  seg_sel_check #(.NUM_SEGS(NUM_SEGS), .CODE_ID(CODE_ID)) u_check (
    .sel_hi    (ld_selector[15:2]),
    .seg_id    (ld_seg_id),
    .xfer      (ld_xfer),
    .gbase     (gtab_base),
    .glimit    (gtab_limit),
    .lbase     (ltab_base),
    .llimit    (ltab_limit),
    .desc_addr (desc_addr),
    .refuse    (refuse)
  );

  seg_fetch_fsm u_fetch (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept && !refuse),
    .start_addr    (desc_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (fetch_busy),
    .commit        (commit),
    .lo_dw         (lo_dw),
    .hi_dw         (hi_dw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q    <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (accept) begin
        id_q  <= ld_seg_id;
        sel_q <= ld_selector;
      end
      done_q  <= commit || (accept && refuse);
      fault_q <= accept && refuse;
    end
  end

  assign wentry = unpack_desc(sel_q, lo_dw, hi_dw);

  seg_desc_cache #(.NUM_SEGS(NUM_SEGS)) u_cache (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (commit),
    .wid    (id_q),
    .wdata  (wentry),
    .rid    (rd_seg_id),
    .rdata  (rentry),
    .rvalid (rd_valid)
  );

  assign rd_selector = rentry.selector;
  assign rd_base     = rentry.base;
  assign rd_limit    = rentry.limit;
  assign rd_gran     = rentry.gran;
  assign rd_dpl      = rentry.dpl;
  assign rd_access   = rentry.access;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk #(
  parameter int NUM_SEGS = 6,
  parameter int CODE_ID  = 1,
  localparam int ID_W    = $clog2(NUM_SEGS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_valid,
  input logic            ld_ready,
  input logic [ID_W-1:0] ld_seg_id,
  input logic            ld_xfer,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [31:0]     mem_req_addr,
  input logic            busy,
  input logic            ld_done,
  input logic            ld_fault
);
  // R7
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R5
  cs_move_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && (ld_seg_id == ID_W'(CODE_ID)) && !ld_xfer
      |=> ld_fault && !busy);

  // R6
  fault_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> !mem_req_valid && !busy);

  // R4
  fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> ld_done);

  // R7
  busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ld_done && !ld_fault);
endmodule

bind seg_load_unit seg_load_chk #(.NUM_SEGS(NUM_SEGS), .CODE_ID(CODE_ID)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ld_valid      (ld_valid),
  .ld_ready      (ld_ready),
  .ld_seg_id     (ld_seg_id),
  .ld_xfer       (ld_xfer),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .busy          (busy),
  .ld_done       (ld_done),
  .ld_fault      (ld_fault)
);

// File: tb/seg_load_unit_bench.sv
module seg_load_unit_bench;
  localparam int NSEG = 6;
  localparam int IDW  = 3;
  localparam int CSID = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            ld_valid = 1'b0;
  logic            ld_ready;
  logic [15:0]     ld_selector = '0;
  logic [IDW-1:0]  ld_seg_id = '0;
  logic            ld_xfer = 1'b0;
  logic [31:0]     gtab_base = 32'h0001_0000;
  logic [15:0]     gtab_limit = 16'h01FF;
  logic [31:0]     ltab_base = 32'h0002_0000;
  logic [15:0]     ltab_limit = 16'h00FF;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic [31:0]     mem_req_addr;
  logic            mem_rsp_valid = 1'b0;
  logic [31:0]     mem_rsp_data = '0;
  logic            busy, ld_done, ld_fault;
  logic [IDW-1:0]  rd_seg_id = '0;
  logic            rd_valid;
  logic [15:0]     rd_selector;
  logic [31:0]     rd_base;
  logic [19:0]     rd_limit;
  logic            rd_gran;
  logic [1:0]      rd_dpl;
  logic [7:0]      rd_access;

  seg_load_unit #(.NUM_SEGS(NSEG), .CODE_ID(CSID)) u_seg_load_unit (.*);

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory model
  bit          ov_en = 1'b0;
  logic [31:0] ov_addr = '0, ov_lo = '0, ov_hi = '0;
  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    if (ov_en && a == ov_addr) return ov_lo;
    if (ov_en && a == ov_addr + 32'd4) return ov_hi;
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  bit          rsp_pend = 1'b0;
  int unsigned rsp_dly = 0;
  logic [31:0] rsp_word = '0;
  int unsigned req_cnt = 0;
  logic [31:0] req_addr [2];

  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (rsp_dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rsp_word;
          rsp_pend      = 1'b0;
        end else rsp_dly--;
      end
      mem_req_ready = !rsp_pend && !mem_rsp_valid && ($urandom % 3 != 0);
      if (mem_req_valid && mem_req_ready) begin
        if (req_cnt < 2) req_addr[req_cnt] = mem_req_addr;
        req_cnt++;
        rsp_word = mem_fn(mem_req_addr);
        rsp_dly  = $urandom % 3;
        rsp_pend = 1'b1;
      end
    end
  end

  // expected cache
  bit          e_vld [NSEG];
  logic [15:0] e_sel [NSEG];
  logic [31:0] e_base [NSEG];
  logic [19:0] e_lim [NSEG];
  logic        e_gran [NSEG];
  logic [1:0]  e_dpl [NSEG];
  logic [7:0]  e_acc [NSEG];

  task automatic check_cache(input string tag);
    for (int j = 0; j < NSEG; j++) begin
      rd_seg_id = IDW'(j);
      #1;
      chk(rd_valid == e_vld[j], {tag, " valid"}, 64'(rd_valid), 64'(e_vld[j]));
      chk(rd_selector == e_sel[j], {tag, " selector"}, 64'(rd_selector), 64'(e_sel[j]));
      chk(rd_base == e_base[j], {tag, " base"}, 64'(rd_base), 64'(e_base[j]));
      chk(rd_limit == e_lim[j], {tag, " limit"}, 64'(rd_limit), 64'(e_lim[j]));
      chk(rd_gran == e_gran[j], {tag, " gran"}, 64'(rd_gran), 64'(e_gran[j]));
      chk(rd_dpl == e_dpl[j], {tag, " dpl"}, 64'(rd_dpl), 64'(e_dpl[j]));
      chk(rd_access == e_acc[j], {tag, " access"}, 64'(rd_access), 64'(e_acc[j]));
    end
  endtask

  task automatic do_load(input logic [15:0] sel, input logic [IDW-1:0] id, input bit xfer, input string tag);
    logic [12:0] idx;
    bit          loc, exp_ref;
    logic [31:0] addr, lo, hi;
    logic [63:0] d;
    int          wait_n;
    idx     = sel[15:3];
    loc     = sel[2];
    addr    = (loc ? ltab_base : gtab_base) + {16'd0, idx, 3'b000};
    exp_ref = (id == IDW'(CSID) && !xfer) || (int'(id) >= NSEG) ||
              ({idx, 3'b111} > (loc ? ltab_limit : gtab_limit));
    @(negedge clk);
    chk(ld_ready == 1'b1, {tag, " R7 ready idle"}, 64'(ld_ready), 64'd1);
    req_cnt     = 0;
    ld_valid    = 1'b1;
    ld_selector = sel;
    ld_seg_id   = id;
    ld_xfer     = xfer;
    @(negedge clk);
    ld_valid = 1'b0;
    if (!exp_ref) begin
      chk(busy == 1'b1, {tag, " R7 busy rises"}, 64'(busy), 64'd1);
      chk(ld_ready == 1'b0, {tag, " R7 ready low"}, 64'(ld_ready), 64'd0);
    end
    wait_n = 0;
    while (!ld_done && wait_n < 200) begin
      @(negedge clk);
      wait_n++;
    end
    chk(ld_done == 1'b1, {tag, " R4 done seen"}, 64'(ld_done), 64'd1);
    chk(ld_fault == exp_ref, {tag, " R5 R6 R10 fault"}, 64'(ld_fault), 64'(exp_ref));
    chk(busy == 1'b0, {tag, " R7 busy low at done"}, 64'(busy), 64'd0);
    chk(req_cnt == (exp_ref ? 0 : 2), {tag, " R2 read count"}, 64'(req_cnt), exp_ref ? 64'd0 : 64'd2);
    if (!exp_ref && req_cnt == 2) begin
      chk(req_addr[0] == addr, {tag, " R1 low addr"}, 64'(req_addr[0]), 64'(addr));
      chk(req_addr[1] == addr + 32'd4, {tag, " R2 high addr"}, 64'(req_addr[1]), 64'(addr + 32'd4));
    end
    if (!exp_ref && int'(id) < NSEG) begin
      lo = mem_fn(addr);
      hi = mem_fn(addr + 32'd4);
      d  = {hi, lo};
      e_vld[id]  = 1'b1;
      e_sel[id]  = sel;
      e_base[id] = {d[63:56], d[39:16]};
      e_lim[id]  = {d[51:48], d[15:0]};
      e_gran[id] = d[55];
      e_dpl[id]  = d[46:45];
      e_acc[id]  = d[47:40];
    end
    check_cache({tag, " R3 R4 cache"});
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int j = 0; j < NSEG; j++) begin
      e_vld[j] = 0; e_sel[j] = '0; e_base[j] = '0; e_lim[j] = '0;
      e_gran[j] = 0; e_dpl[j] = '0; e_acc[j] = '0;
    end
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 1'b0, "R8 busy at reset", 64'(busy), 64'd0);
    chk(ld_ready == 1'b1, "R8 ready at reset", 64'(ld_ready), 64'd1);
    check_cache("R8 reset cache");
    rst_n = 1'b1;

    // R3 flat descriptor example, RPL 3 ignored (R1)
    ov_en = 1'b1; ov_addr = gtab_base + 32'd40;
    ov_lo = 32'h0000_FFFF; ov_hi = 32'h00CF_FA00;
    do_load({13'd5, 1'b0, 2'b11}, 3'd2, 1'b0, "R3 flat");
    rd_seg_id = 3'd2; #1;
    chk(rd_limit == 20'hFFFFF && rd_dpl == 2'd3 && rd_base == 0 && rd_gran && rd_access == 8'hFA,
        "R3 flat literal", 64'({rd_base, rd_limit}), 64'h000F_FFFF);
    ov_en = 1'b0;

    // R5 move into code register refused
    do_load({13'd2, 1'b0, 2'b00}, 3'(CSID), 1'b0, "R5 cs move");
    // R9 control transfer into code register
    do_load({13'd2, 1'b0, 2'b00}, 3'(CSID), 1'b1, "R9 cs xfer");
    // R10 id out of range
    do_load({13'd1, 1'b0, 2'b00}, 3'd7, 1'b1, "R10 id7");
    do_load({13'd1, 1'b1, 2'b00}, 3'd6, 1'b0, "R10 id6");
    // R6 limit boundary, both tables
    gtab_limit = 16'h002F;
    do_load({13'd5, 1'b0, 2'b01}, 3'd0, 1'b0, "R6 global end equals limit");
    do_load({13'd6, 1'b0, 2'b01}, 3'd0, 1'b0, "R6 global overrun");
    ltab_limit = 16'h0017;
    do_load({13'd2, 1'b1, 2'b10}, 3'd3, 1'b0, "R6 R1 local end equals limit");
    do_load({13'd3, 1'b1, 2'b10}, 3'd3, 1'b0, "R6 local overrun");

    // random mix
    for (int k = 0; k < 150; k++) begin
      if (k % 25 == 0) begin
        gtab_base  = $urandom;
        ltab_base  = $urandom;
        gtab_limit = 16'($urandom % 16'h0200);
        ltab_limit = 16'($urandom % 16'h0200);
      end
      do_load({13'($urandom % 64), 1'($urandom), 2'($urandom)}, 3'($urandom % 8),
              1'($urandom), "R1 R2 R3 random");
    end
    finish_run();
  end
endmodule